// File: doc/BRIEF.md
# Transmit Deferral and Retry Controller

This block sits in the transmit path of a 10 Mbit/s Ethernet MAC and decides when a queued frame may go out. It measures the inter-frame gap from the carrier-sense input. The gap has two parts. In the first, carrier-sensitive part, carrier restarts the measurement. In the second, blind part, carrier is ignored while a frame is waiting. During transmission it extends short frames with pad bytes ahead of the checksum. On a collision it drives a 32-bit jam, then waits a caller-supplied number of slot times, then re-enters deferral. After sixteen failed attempts it gives up and reports an error. A small receive-side filter flags received frames that collide early, so that they can be discarded silently.

All timing advances only on cycles where the bit-time enable is high (one pulse per 100 ns bit). Strobes from the serializer are sampled on those cycles. Pulse outputs last one clock cycle. The serializer, checksum generator, backoff random source and line coding live outside this block.

Top module: `tx_defer_ctrl`

## Requirements
- R1: After synchronous reset, tx_start, pad_req, jam_on, retry_req, retry_err, tx_ok and rx_drop are all low.
- R2: With frame_pend high and carrier low from bit-enable n=1 onward, tx_start pulses right after enable n=97, which is a 96-bit gap (60 + 36) plus one decision cycle.
- R3: Carrier that is seen on enable k while the gap count is below 60 (k ≤ 60) restarts the gap, so tx_start follows enable k+97.
- R4: Carrier that is seen during the second part of the gap (k ≥ 61) while frame_pend is high is ignored, and tx_start still follows enable 97.
- R5: Carrier that is seen during the second part of the gap while frame_pend is low restarts the gap.
- R6: Clock cycles with bit_en low do not advance any timing. A stall of L cycles delays tx_start by L cycles.
- R7: The block counts byte_done strobes from tx_start, with the 8 preamble bytes included. If the strobe flagged with data_end brings the count below 68 bytes (544 bits), pad_req rises and stays high until the count reaches 68. Otherwise pad_req stays low.
- R8: A collision during transmission raises jam_on for exactly 32 bit enables. retry_req then pulses on the enable that ends the jam.
- R9: After retry_req, the next tx_start comes max(97, S·512+2) enables later, where S is the backoff_slots value.
- R10: A frame gets at most 16 attempts. The first 15 collisions each give retry_req. The 16th gives retry_err and no retry_req. The next frame starts with a fresh attempt count.
- R11: tx_end during transmission gives a tx_ok pulse, returns to deferral and clears the attempt count.
- R12: While rx_act is high, a collision on enables 1 to 512 of the receive gives a single rx_drop pulse per frame. A collision later than that gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle bit-time enable (10 MHz) |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| frame_pend | input | 1 | A frame is queued for transmit |
| byte_done | input | 1 | Serializer finished one byte (preamble included) |
| data_end | input | 1 | With byte_done: that byte was the last data byte |
| tx_end | input | 1 | Checksum sent, frame complete |
| rx_act | input | 1 | Receive in progress, preamble already stripped |
| backoff_slots | input | SLOTS_W | Slot times to wait after the jam |
| tx_start | output | 1 | Pulse: start transmitting the frame |
| pad_req | output | 1 | Send a pad byte next |
| jam_on | output | 1 | Jam pattern being sent |
| retry_req | output | 1 | Pulse: attempt failed, retry scheduled |
| retry_err | output | 1 | Pulse: sixteenth attempt failed, frame dropped |
| tx_ok | output | 1 | Pulse: frame sent successfully |
| rx_drop | output | 1 | Pulse: received frame collided early, discard it |

## Verification
If the gap counter is off by one, tx_start moves by a whole bit time. The bench measures the delay in enables for every carrier pattern, so the error shows on the first frame. If the blind-phase decision is wrong, the restart boundary moves between enables 60 and 61, which the directed edge cases probe. A wrong attempt counter shows up as a retry_req where retry_err is expected, or the reverse, on the 16th collision or on the first collision of the next frame. An error in the byte count or the backoff load changes the number of pad bytes or the retry-to-start delay, and it shows within one frame.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_JAM  = 2'd2,
    ST_BACK = 2'd3
  } tdc_state_t;
endpackage

// File: rtl/tdc_gap_timer.sv
module tdc_gap_timer #(
  parameter int GAP1_BITS = 60,
  parameter int GAP2_BITS = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic crs,
  input  logic pend,
  input  logic hold,
  output logic gap_ok
);
  localparam int TOTAL = GAP1_BITS + GAP2_BITS;
  localparam int W     = $clog2(TOTAL + 1);

  logic [W-1:0] cnt;
  logic         blind;

  assign blind  = cnt >= W'(GAP1_BITS);
  assign gap_ok = cnt == W'(TOTAL);

  // Own transmission or carrier restarts the gap; in the blind part a
  // waiting frame masks the carrier.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (bit_en) begin
      if (hold || (crs && !(blind && pend))) cnt <= '0;
      else if (!gap_ok)                     cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_pad_unit.sv
module tdc_pad_unit #(
  parameter int MIN_BITS  = 544,
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic start,
  input  logic active,
  input  logic byte_done,
  input  logic data_end,
  output logic pad_q
);
  localparam int MINB = MIN_BITS / BYTE_BITS;
  localparam int W    = $clog2(MINB + 2);

  logic [W-1:0] bcnt;
  logic [W-1:0] nxt;

  assign nxt = bcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt  <= '0;
      pad_q <= 1'b0;
    end else if (bit_en) begin
      if (start) begin
        bcnt  <= '0;
        pad_q <= 1'b0;
      end else if (!active) begin
        pad_q <= 1'b0;
      end else if (byte_done) begin
        if (bcnt != W'(MINB)) bcnt <= nxt;
        if (data_end)                       pad_q <= nxt < W'(MINB);
        else if (pad_q && nxt >= W'(MINB))  pad_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdc_retry_fsm.sv
module tdc_retry_fsm
  import tdc_pkg::*;
#(
  parameter int JAM_BITS  = 32,
  parameter int SLOT_BITS = 512,
  parameter int MAX_TRIES = 16,
  parameter int SLOTS_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               pend,
  input  logic               gap_ok,
  input  logic               col,
  input  logic               tx_end,
  input  logic [SLOTS_W-1:0] slots,
  output logic               go,
  output logic               in_tx,
  output logic               hold,
  output logic               jam_on,
  output logic               tx_start,
  output logic               retry_req,
  output logic               retry_err,
  output logic               tx_ok
);
  localparam int JW = $clog2(JAM_BITS);
  localparam int BW = SLOTS_W + $clog2(SLOT_BITS);
  localparam int AW = $clog2(MAX_TRIES + 1);

  tdc_state_t    st;
  logic [JW-1:0] jcnt;
  logic [BW-1:0] bcnt;
  logic [AW-1:0] att;

  assign go     = bit_en && (st == ST_IDLE) && pend && gap_ok;
  assign in_tx  = st == ST_TX;
  assign jam_on = st == ST_JAM;
  assign hold   = (st == ST_TX) || (st == ST_JAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      jcnt      <= '0;
      bcnt      <= '0;
      att       <= '0;
      tx_start  <= 1'b0;
      retry_req <= 1'b0;
      retry_err <= 1'b0;
      tx_ok     <= 1'b0;
    end else begin
      tx_start  <= 1'b0;
      retry_req <= 1'b0;
      retry_err <= 1'b0;
      tx_ok     <= 1'b0;
      if (bit_en) begin
        case (st)
          ST_IDLE: if (pend && gap_ok) begin
            st       <= ST_TX;
            tx_start <= 1'b1;
            att      <= att + 1'b1;
          end
          ST_TX: if (col) begin
            st   <= ST_JAM;
            jcnt <= '0;
          end else if (tx_end) begin
            st    <= ST_IDLE;
            tx_ok <= 1'b1;
            att   <= '0;
          end
          ST_JAM: if (jcnt == JW'(JAM_BITS - 1)) begin
            if (att == AW'(MAX_TRIES)) begin
              st        <= ST_IDLE;
              retry_err <= 1'b1;
              att       <= '0;
            end else begin
              st        <= ST_BACK;
              retry_req <= 1'b1;
              bcnt      <= BW'(slots) * BW'(SLOT_BITS);
            end
          end else begin
            jcnt <= jcnt + 1'b1;
          end
          ST_BACK: if (bcnt == '0) st <= ST_IDLE;
                   else            bcnt <= bcnt - 1'b1;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tdc_rx_filter.sv
module tdc_rx_filter #(
  parameter int RX_WIN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_act,
  input  logic col,
  output logic rx_drop
);
  localparam int W = $clog2(RX_WIN + 1);

  logic [W-1:0] cnt;
  logic         flagged;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      flagged <= 1'b0;
      rx_drop <= 1'b0;
    end else begin
      rx_drop <= 1'b0;
      if (bit_en) begin
        if (!rx_act) begin
          cnt     <= '0;
          flagged <= 1'b0;
        end else begin
          if (cnt != W'(RX_WIN)) cnt <= cnt + 1'b1;
          if (col && (cnt < W'(RX_WIN)) && !flagged) begin
            rx_drop <= 1'b1;
            flagged <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tx_defer_ctrl.sv
module tx_defer_ctrl #(
  parameter int GAP1_BITS = 60,
  parameter int GAP2_BITS = 36,
  parameter int MIN_BITS  = 544,
  parameter int JAM_BITS  = 32,
  parameter int SLOT_BITS = 512,
  parameter int MAX_TRIES = 16,
  parameter int SLOTS_W   = 10,
  parameter int RX_WIN    = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               crs,
  input  logic               col,
  input  logic               frame_pend,
  input  logic               byte_done,
  input  logic               data_end,
  input  logic               tx_end,
  input  logic               rx_act,
  input  logic [SLOTS_W-1:0] backoff_slots,
  output logic               tx_start,
  output logic               pad_req,
  output logic               jam_on,
  output logic               retry_req,
  output logic               retry_err,
  output logic               tx_ok,
  output logic               rx_drop
);
  logic gap_ok, go, in_tx, hold, pad_q;

  tdc_gap_timer #(.GAP1_BITS(GAP1_BITS), .GAP2_BITS(GAP2_BITS)) u_gap (
    .clk(clk), .rst(rst), .bit_en(bit_en), .crs(crs), .pend(frame_pend),
    .hold(hold), .gap_ok(gap_ok)
  );

  tdc_retry_fsm #(
    .JAM_BITS(JAM_BITS), .SLOT_BITS(SLOT_BITS),
    .MAX_TRIES(MAX_TRIES), .SLOTS_W(SLOTS_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pend(frame_pend), .gap_ok(gap_ok),
    .col(col), .tx_end(tx_end), .slots(backoff_slots), .go(go), .in_tx(in_tx),
    .hold(hold), .jam_on(jam_on), .tx_start(tx_start), .retry_req(retry_req),
    .retry_err(retry_err), .tx_ok(tx_ok)
  );

  tdc_pad_unit #(.MIN_BITS(MIN_BITS), .BYTE_BITS(8)) u_pad (
    .clk(clk), .rst(rst), .bit_en(bit_en), .start(go), .active(in_tx),
    .byte_done(byte_done), .data_end(data_end), .pad_q(pad_q)
  );

  assign pad_req = pad_q & in_tx;

  tdc_rx_filter #(.RX_WIN(RX_WIN)) u_rx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_act(rx_act), .col(col),
    .rx_drop(rx_drop)
  );
endmodule

// File: rtl/tx_defer_ctrl_chk.sv
module tx_defer_ctrl_chk #(
  parameter int JAM_BITS = 32
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic frame_pend,
  input logic col,
  input logic tx_end,
  input logic rx_act,
  input logic tx_start,
  input logic jam_on,
  input logic retry_req,
  input logic retry_err,
  input logic tx_ok,
  input logic rx_drop
);
  logic [15:0] jrun;

  always_ff @(posedge clk) begin
    if (rst)                  jrun <= '0;
    else if (!jam_on)         jrun <= '0;
    else if (bit_en)          jrun <= jrun + 1'b1;
  end

  a_r2_start_needs_pend: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(frame_pend));

  a_r8_jam_length: assert property (@(posedge clk) disable iff (rst)
    jam_on |-> (jrun < 16'(JAM_BITS)));

  a_r8_retry_after_jam: assert property (@(posedge clk) disable iff (rst)
    retry_req |-> $past(jam_on));

  a_r10_err_after_jam: assert property (@(posedge clk) disable iff (rst)
    retry_err |-> $past(jam_on));

  a_r10_single_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_start, retry_req, retry_err, tx_ok}));

  a_r11_ok_after_end: assert property (@(posedge clk) disable iff (rst)
    tx_ok |-> $past(tx_end));

  a_r12_drop_cause: assert property (@(posedge clk) disable iff (rst)
    rx_drop |-> $past(col && rx_act));
endmodule

bind tx_defer_ctrl tx_defer_ctrl_chk #(.JAM_BITS(JAM_BITS)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .frame_pend(frame_pend), .col(col),
  .tx_end(tx_end), .rx_act(rx_act), .tx_start(tx_start), .jam_on(jam_on),
  .retry_req(retry_req), .retry_err(retry_err), .tx_ok(tx_ok), .rx_drop(rx_drop)
);

// File: tb/sim_tx_defer_ctrl.sv
`timescale 1ns/1ps
module sim_tx_defer_ctrl;
  localparam int GAP  = 96;
  localparam int MINB = 68;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b1, crs = 1'b1, col = 1'b0, frame_pend = 1'b0;
  logic       byte_done = 1'b0, data_end = 1'b0, tx_end = 1'b0, rx_act = 1'b0;
  logic [9:0] backoff_slots = '0;
  logic       tx_start, pad_req, jam_on, retry_req, retry_err, tx_ok, rx_drop;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx_defer_ctrl u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .crs(crs), .col(col),
    .frame_pend(frame_pend), .byte_done(byte_done), .data_end(data_end),
    .tx_end(tx_end), .rx_act(rx_act), .backoff_slots(backoff_slots),
    .tx_start(tx_start), .pad_req(pad_req), .jam_on(jam_on),
    .retry_req(retry_req), .retry_err(retry_err), .tx_ok(tx_ok), .rx_drop(rx_drop)
  );

  function automatic int exp_gap(input int pulse_at, input bit pend_at_pulse,
                                 input int stall);
    int d = GAP + 1;
    if (pulse_at > 0 && (pulse_at <= 60 || !pend_at_pulse)) d = pulse_at + GAP + 1;
    return d + stall;
  endfunction

  function automatic int exp_retry(input int s);
    return (s * 512 + 2 > GAP + 1) ? s * 512 + 2 : GAP + 1;
  endfunction

  function automatic int exp_pads(input int n);
    return (n < MINB) ? MINB - n : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic prep();
    frame_pend = 1'b0; crs = 1'b1; col = 1'b0; bit_en = 1'b1;
    repeat (3) step();
  endtask

  // Carrier drops now; counts enables until tx_start.
  task automatic gap_run(input int pulse_at, input int pend_from,
                         input int stall_at, input int stall_len, output int n);
    bit found = 1'b0;
    n = 0;
    while (!found && n < 2000) begin
      crs        = (pulse_at != 0) && (n + 1 == pulse_at);
      frame_pend = (n + 1 >= pend_from);
      bit_en     = !((stall_len != 0) && (n + 1 > stall_at) && (n + 1 <= stall_at + stall_len));
      step();
      n++;
      if (tx_start) found = 1'b1;
    end
    crs = 1'b0; bit_en = 1'b1;
  endtask

  task automatic finish_frame(input string req);
    tx_end = 1'b1;
    step();
    tx_end = 1'b0;
    check(req, int'(tx_ok), 1);
    frame_pend = 1'b0;
  endtask

  task automatic collide(input int s, output int jams, output bit rr, output bit re);
    backoff_slots = 10'(s);
    col = 1'b1;
    step();
    col = 1'b0;
    jams = 0;
    while (!(retry_req || retry_err) && jams < 100) begin
      if (jam_on) jams++;
      step();
    end
    rr = retry_req;
    re = retry_err;
  endtask

  task automatic wait_start(output int d);
    d = 0;
    while (!tx_start && d < 3000) begin
      step();
      d++;
    end
  endtask

  task automatic pad_frame(input int n);
    int d, pads;
    prep();
    gap_run(0, 0, 0, 0, d);
    for (int i = 1; i <= n; i++) begin
      byte_done = 1'b1;
      data_end  = (i == n);
      step();
      if (i == n - 1) check("R7 no pad before data end", int'(pad_req), 0);
    end
    data_end = 1'b0;
    byte_done = 1'b0;
    check("R7 pad flag after data end", int'(pad_req), int'(n < MINB));
    pads = 0;
    while (pad_req && pads < 200) begin
      byte_done = 1'b1;
      step();
      pads++;
    end
    byte_done = 1'b0;
    check("R7 pad byte count", pads, exp_pads(n));
    finish_frame("R11 ok after padded frame");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int d, j, k;
    bit rr, re;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    check("R1 tx_start reset", int'(tx_start), 0);
    check("R1 jam reset", int'(jam_on), 0);
    rst = 1'b0;
    step();
    check("R1 outputs idle", int'({tx_start, pad_req, jam_on, retry_req,
                                    retry_err, tx_ok, rx_drop}), 0);

    // R2 plain gap
    prep(); gap_run(0, 0, 0, 0, d);
    check("R2 gap delay", d, exp_gap(0, 1'b1, 0));
    finish_frame("R11 tx_ok");

    // R3 restart boundary and random in first part
    prep(); gap_run(60, 0, 0, 0, d);
    check("R3 carrier at 60 restarts", d, exp_gap(60, 1'b1, 0));
    finish_frame("R11 tx_ok");
    k = 1 + int'($urandom % 60);
    prep(); gap_run(k, 0, 0, 0, d);
    check("R3 carrier early restarts", d, exp_gap(k, 1'b1, 0));
    finish_frame("R11 tx_ok");

    // R4 blind part with pending frame
    prep(); gap_run(61, 0, 0, 0, d);
    check("R4 carrier at 61 ignored", d, exp_gap(61, 1'b1, 0));
    finish_frame("R11 tx_ok");
    k = 61 + int'($urandom % 35);
    prep(); gap_run(k, 0, 0, 0, d);
    check("R4 blind carrier ignored", d, exp_gap(k, 1'b1, 0));
    finish_frame("R11 tx_ok");

    // R5 blind part without pending frame
    prep(); gap_run(70, 71, 0, 0, d);
    check("R5 no pend carrier restarts", d, exp_gap(70, 1'b0, 0));
    finish_frame("R11 tx_ok");

    // R6 enable stall
    prep(); gap_run(0, 0, 10, 50, d);
    check("R6 stall delays start", d, exp_gap(0, 1'b1, 50));
    finish_frame("R11 tx_ok");

    // R7 padding
    pad_frame(20);
    pad_frame(67);
    pad_frame(68);
    pad_frame(100);
    pad_frame(9 + int'($urandom % 100));

    // R8 / R9 collisions with backoff
    for (int s = 0; s < 3; s++) begin
      prep(); gap_run(0, 0, 0, 0, d);
      collide(s, j, rr, re);
      check("R8 jam length", j, 32);
      check("R8 retry_req after jam", int'(rr), 1);
      wait_start(d);
      check("R9 backoff delay", d, exp_retry(s));
      finish_frame("R11 tx_ok after retry");
    end
    k = int'($urandom % 4);
    prep(); gap_run(0, 0, 0, 0, d);
    collide(k, j, rr, re);
    wait_start(d);
    check("R9 random backoff delay", d, exp_retry(k));
    finish_frame("R11 tx_ok");

    // R10 sixteen attempts
    prep(); gap_run(0, 0, 0, 0, d);
    for (int a = 1; a <= 16; a++) begin
      collide(0, j, rr, re);
      if (a < 16) begin
        check("R10 retry before limit", int'(rr), 1);
        wait_start(d);
        check("R10 restart after retry", d, exp_retry(0));
      end else begin
        check("R10 no retry at limit", int'(rr), 0);
        check("R10 retry_err at limit", int'(re), 1);
      end
    end
    frame_pend = 1'b0;
    prep(); gap_run(0, 0, 0, 0, d);
    collide(0, j, rr, re);
    check("R10 fresh count next frame", int'(re), 0);
    wait_start(d);
    finish_frame("R11 tx_ok");

    // R11 attempts cleared after success: 15 collisions, success, then 1 more
    prep(); gap_run(0, 0, 0, 0, d);
    for (int a = 1; a <= 15; a++) begin
      collide(0, j, rr, re);
      wait_start(d);
    end
    finish_frame("R11 tx_ok after 15 retries");
    prep(); gap_run(0, 0, 0, 0, d);
    collide(0, j, rr, re);
    check("R11 attempt count cleared", int'(rr), 1);
    wait_start(d);
    finish_frame("R11 tx_ok");

    // R12 receive collision window
    prep(); crs = 1'b0;
    rx_act = 1'b1;
    repeat (511) step();
    col = 1'b1; step(); col = 1'b0;
    check("R12 drop at 512", int'(rx_drop), 1);
    col = 1'b1; step(); col = 1'b0;
    check("R12 single drop per frame", int'(rx_drop), 0);
    rx_act = 1'b0; step();
    rx_act = 1'b1;
    repeat (512) step();
    col = 1'b1; step(); col = 1'b0;
    check("R12 no drop at 513", int'(rx_drop), 0);
    rx_act = 1'b0; step();
    k = 1 + int'($urandom % 512);
    rx_act = 1'b1;
    repeat (k - 1) step();
    col = 1'b1; step(); col = 1'b0;
    check("R12 drop inside window", int'(rx_drop), 1);
    rx_act = 1'b0; step();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule